// File: doc/BRIEF.md
# Dual Parallel Port Register Block

This block gives a processor-side byte bus access to 48 general-purpose I/O lines. The lines are grouped into two identical banks, and each bank holds three 8-bit ports (A, B and C) plus one control byte. All eight registers share one 8-byte window. A write to a port offset loads that port's output latch. A read of a port offset returns the synchronized levels seen on the pins. The control byte of each bank sets which lines drive and which lines only listen. Ports A and B switch direction as whole bytes. Port C switches as two independent nibbles.

A control byte takes effect only when its top bit is 1. A control byte with its top bit clear is discarded, so software cannot change direction by accident with a plain data pattern. Every input line passes through a two-flop synchronizer before it reaches the read path. Bus reads are registered, so read data is valid in the cycle after the read strobe.

Top module: `dual_pport_regs`

## Requirements
- R1: After reset, every output enable is 0, every output latch holds 0x00, `bus_rdata` is 0, and a read of either control offset (3 or 7) returns 0x9B, the control byte that selects input for all lines.
- R2: A write to offsets 0, 1 or 2 loads bank 1 port A, B or C. A write to offsets 4, 5 or 6 loads the same ports of bank 2. The new latch value appears on `pin_out` in the cycle after the write strobe.
- R3: In a bank's accepted control byte, bit 4 = 1 makes all of port A input (enables 0) and bit 1 = 1 makes all of port B input. A 0 in either bit makes that port an output.
- R4: Control bit 3 sets the direction of port C bits 7..4, and control bit 0 sets the direction of port C bits 3..0. A 1 selects input. The two nibbles are independent.
- R5: A write to a control offset with bit 7 = 0 is ignored. The output enables and the control readback are unchanged.
- R6: Writing 0x80 to a control offset makes all 24 lines of that bank outputs and leaves the other bank unchanged.
- R7: A read of a port offset returns that port's pin levels after a two-flop synchronizer. `bus_rdata` reflects the pin value from two clock edges before the read edge, and it is valid in the cycle after `bus_rd`.
- R8: A read of a control offset returns the last control byte accepted for that bank.
- R9: A control write leaves every output latch unchanged. Lines switched to output drive the value already latched, including a value written while those lines were inputs.
- R10: In any cycle after a clock edge without `bus_rd`, `bus_rdata` is 0.
- R11: Line n of bank b is on pin index b*24 + n. Its port is n/8 (A=0, B=1, C=2) and its bit is n%8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Byte offset in the register window |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data, valid the cycle after `bus_rd` |
| pin_in | input | 48 | Pin levels seen at the pads |
| pin_out | output | 48 | Output latch values, one per line |
| pin_oe | output | 48 | Output enable per line, 1 = drive |

## Verification
The bench builds the block with its default parameters: two banks, 8-bit ports and a two-stage synchronizer. With these values the bank select bit of the address and the nibble split of port C are both exercised, and the read latency is short enough to compare exactly on every clock. The bench models the pads as a loopback, so each driven line reads back its own latch. This shows how the synchronizer delays a direction change before it reaches the read data.

// File: rtl/ppr_pkg.sv
package ppr_pkg;
  // Control byte fields (bit positions are decoded by the bank logic)
  localparam int CTL_ACCEPT_BIT = 7;
  localparam int CTL_A_IN_BIT   = 4;
  localparam int CTL_CHI_IN_BIT = 3;
  localparam int CTL_B_IN_BIT   = 1;
  localparam int CTL_CLO_IN_BIT = 0;

  localparam int PORTS_PER_BANK = 3;
  localparam int SLOTS_PER_BANK = 4;

  // Reset control: accept flag plus every direction bit set to input
  localparam logic [7:0] CTL_RESET = 8'h9B;

  typedef enum logic [1:0] {
    SLOT_A   = 2'd0,
    SLOT_B   = 2'd1,
    SLOT_C   = 2'd2,
    SLOT_CTL = 2'd3
  } slot_e;
endpackage

// File: rtl/ppr_sync.sv
module ppr_sync #(
  parameter int WIDTH  = 48,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/ppr_bank.sv
module ppr_bank
  import ppr_pkg::*;
#(
  parameter int PORT_W = 8,
  localparam int BANK_W = PORTS_PER_BANK * PORT_W,
  localparam int NIB_LO = PORT_W / 2,
  localparam int NIB_HI = PORT_W - NIB_LO
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [1:0]        slot,
  input  logic [PORT_W-1:0] wdata,
  input  logic [BANK_W-1:0] pin_sync,
  output logic [BANK_W-1:0] lat_out,
  output logic [BANK_W-1:0] oe_out,
  output logic [PORT_W-1:0] rd_val
);
  logic [PORT_W-1:0] ctl_q;
  logic [PORT_W-1:0] lat_a, lat_b, lat_c;
  logic [BANK_W-1:0] oe_q;
  logic              ctl_take;

  // Direction decode: a 1 in a direction bit selects input (enable low)
  function automatic logic [BANK_W-1:0] dir_to_oe(input logic [PORT_W-1:0] c);
    dir_to_oe = {{NIB_HI{~c[CTL_CHI_IN_BIT]}}, {NIB_LO{~c[CTL_CLO_IN_BIT]}},
                 {PORT_W{~c[CTL_B_IN_BIT]}}, {PORT_W{~c[CTL_A_IN_BIT]}}};
  endfunction

  assign ctl_take = wr_en && (slot == SLOT_CTL) && wdata[CTL_ACCEPT_BIT];

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q <= PORT_W'(CTL_RESET);
      oe_q  <= '0;
    end else if (ctl_take) begin
      ctl_q <= wdata;
      oe_q  <= dir_to_oe(wdata);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lat_a <= '0;
      lat_b <= '0;
      lat_c <= '0;
    end else if (wr_en) begin
      case (slot)
        SLOT_A:  lat_a <= wdata;
        SLOT_B:  lat_b <= wdata;
        SLOT_C:  lat_c <= wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (slot)
      SLOT_A:  rd_val = pin_sync[0 +: PORT_W];
      SLOT_B:  rd_val = pin_sync[PORT_W +: PORT_W];
      SLOT_C:  rd_val = pin_sync[2*PORT_W +: PORT_W];
      default: rd_val = ctl_q;
    endcase
  end

  assign lat_out = {lat_c, lat_b, lat_a};
  assign oe_out  = oe_q;
endmodule

// File: rtl/dual_pport_regs.sv
module dual_pport_regs
  import ppr_pkg::*;
#(
  parameter int NUM_BANKS   = 2,
  parameter int PORT_W      = 8,
  parameter int SYNC_STAGES = 2,
  localparam int BANK_W = PORTS_PER_BANK * PORT_W,
  localparam int LINES  = NUM_BANKS * BANK_W,
  localparam int ADDR_W = $clog2(NUM_BANKS) + 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [PORT_W-1:0] bus_wdata,
  output logic [PORT_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  pin_in,
  output logic [LINES-1:0]  pin_out,
  output logic [LINES-1:0]  pin_oe
);
  logic [LINES-1:0]  pin_sync;
  logic [NUM_BANKS-1:0] bank_hit;
  logic [PORT_W-1:0] bank_rd [NUM_BANKS];
  logic [PORT_W-1:0] rd_mux;

  ppr_sync #(.WIDTH(LINES), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (pin_in),
    .q   (pin_sync)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    assign bank_hit[b] = ((bus_addr >> 2) == ADDR_W'(b));

    ppr_bank #(.PORT_W(PORT_W)) u_bank (
      .clk      (clk),
      .rst      (rst),
      .wr_en    (bus_wr && bank_hit[b]),
      .slot     (bus_addr[1:0]),
      .wdata    (bus_wdata),
      .pin_sync (pin_sync[b*BANK_W +: BANK_W]),
      .lat_out  (pin_out[b*BANK_W +: BANK_W]),
      .oe_out   (pin_oe[b*BANK_W +: BANK_W]),
      .rd_val   (bank_rd[b])
    );
  end

  always_comb begin
    rd_mux = '0;
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (bank_hit[b]) rd_mux = bank_rd[b];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)         bus_rdata <= '0;
    else if (bus_rd) bus_rdata <= rd_mux;
    else             bus_rdata <= '0;
  end
endmodule

// File: rtl/ppr_chk.sv
module ppr_chk
  import ppr_pkg::*;
#(
  parameter int NUM_BANKS = 2,
  parameter int PORT_W    = 8,
  localparam int BANK_W = PORTS_PER_BANK * PORT_W,
  localparam int LINES  = NUM_BANKS * BANK_W,
  localparam int ADDR_W = $clog2(NUM_BANKS) + 2
) (
  input logic              clk,
  input logic              rst,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_wr,
  input logic              bus_rd,
  input logic [PORT_W-1:0] bus_wdata,
  input logic [PORT_W-1:0] bus_rdata,
  input logic [LINES-1:0]  pin_out,
  input logic [LINES-1:0]  pin_oe
);
  logic              rst_q;
  logic              wr_port_q;
  logic              wr_ctl_q;
  int                idx_q;
  int                bank_q;
  logic [PORT_W-1:0] data_q;

  always_ff @(posedge clk) begin
    rst_q <= rst;
    if (rst) begin
      wr_port_q <= 1'b0;
      wr_ctl_q  <= 1'b0;
      idx_q     <= 0;
      bank_q    <= 0;
      data_q    <= '0;
    end else begin
      wr_port_q <= bus_wr && (bus_addr[1:0] != SLOT_CTL);
      wr_ctl_q  <= bus_wr && (bus_addr[1:0] == SLOT_CTL);
      bank_q    <= int'(bus_addr >> 2);
      idx_q     <= int'(bus_addr >> 2) * PORTS_PER_BANK + int'(bus_addr[1:0]);
      data_q    <= bus_wdata;
    end
  end

  always @(posedge clk) begin
    // R1
    if (rst_q === 1'b1)
      reset_state_chk: assert (pin_oe == '0 && pin_out == '0 && bus_rdata == '0);
    // R2
    if (!rst && wr_port_q === 1'b1)
      port_write_chk: assert (pin_out[idx_q*PORT_W +: PORT_W] == data_q);
    // R6
    if (!rst && wr_ctl_q === 1'b1 && data_q == PORT_W'(8'h80))
      all_out_chk: assert (pin_oe[bank_q*BANK_W +: BANK_W] == '1);
  end

  // R5
  ignored_ctl_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[1:0] == SLOT_CTL && !bus_wdata[CTL_ACCEPT_BIT]) |=> $stable(pin_oe));

  // R9
  latch_kept_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_wr && bus_addr[1:0] == SLOT_CTL) |=> $stable(pin_out));

  // R10
  idle_rdata_chk: assert property (@(posedge clk) disable iff (rst)
    !bus_rd |=> (bus_rdata == '0));
endmodule

bind dual_pport_regs ppr_chk #(.NUM_BANKS(NUM_BANKS), .PORT_W(PORT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_wr    (bus_wr),
  .bus_rd    (bus_rd),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .pin_out   (pin_out),
  .pin_oe    (pin_oe)
);

// File: tb/dual_pport_regs_tb.sv
`timescale 1ns/1ps
module dual_pport_regs_tb;
  logic        clk;
  logic        rst;
  logic [2:0]  bus_addr;
  logic        bus_wr;
  logic        bus_rd;
  logic [7:0]  bus_wdata;
  logic [7:0]  bus_rdata;
  logic [47:0] pin_in;
  logic [47:0] pin_out;
  logic [47:0] pin_oe;
  logic [47:0] ext;

  int checks = 0;
  int errors = 0;
  int cyc    = 0;

  dual_pport_regs u_dut (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe)
  );

  // Pad model: a driven line reads back its own latch
  assign pin_in = (pin_out & pin_oe) | (ext & ~pin_oe);

  initial begin
    clk = 1'b0;
    forever #5 clk = ~clk;
  end

  // ---------------- reference model ----------------
  logic [7:0]  m_ctl [2];
  logic [7:0]  m_lat [6];
  logic [47:0] hist [$];
  logic [7:0]  m_rdata;

  function automatic logic [47:0] model_oe();
    logic [47:0] r;
    for (int b = 0; b < 2; b++) begin
      for (int n = 0; n < 24; n++) begin
        int port = n / 8;
        int bitn = n % 8;
        logic inp;
        if (port == 0)      inp = m_ctl[b][4];
        else if (port == 1) inp = m_ctl[b][1];
        else if (bitn >= 4) inp = m_ctl[b][3];
        else                inp = m_ctl[b][0];
        r[b*24 + n] = !inp;
      end
    end
    return r;
  endfunction

  function automatic logic [47:0] model_out();
    logic [47:0] r;
    for (int p = 0; p < 6; p++) r[p*8 +: 8] = m_lat[p];
    return r;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_ctl[0] = 8'h9B;
      m_ctl[1] = 8'h9B;
      for (int p = 0; p < 6; p++) m_lat[p] = 8'h00;
      hist.delete();
      hist.push_back(48'h0);
      hist.push_back(48'h0);
      m_rdata = 8'h00;
    end else begin
      logic [47:0] seen;
      int b;
      int s;
      seen = hist.pop_front();
      b = int'(bus_addr[2]);
      s = int'(bus_addr[1:0]);
      if (bus_rd) m_rdata = (s == 3) ? m_ctl[b] : seen[(b*3 + s)*8 +: 8];
      else        m_rdata = 8'h00;
      if (bus_wr) begin
        if (s == 3) begin
          if (bus_wdata[7]) m_ctl[b] = bus_wdata;
        end else begin
          m_lat[b*3 + s] = bus_wdata;
        end
      end
      hist.push_back(pin_in);
    end
  end

  // Per-clock comparison against the model
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (pin_out !== model_out()) begin
        errors++;
        $display("FAIL R2 pin_out actual %h expected %h", pin_out, model_out());
      end
      checks++;
      if (pin_oe !== model_oe()) begin
        errors++;
        $display("FAIL R3 pin_oe actual %h expected %h", pin_oe, model_oe());
      end
      checks++;
      if (bus_rdata !== m_rdata) begin
        errors++;
        $display("FAIL R7 bus_rdata actual %h expected %h", bus_rdata, m_rdata);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(input string tag, input logic [47:0] act, input logic [47:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic do_read(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual %0d expected below 20000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [7:0] rv;
    rst = 1'b1; bus_addr = '0; bus_wr = 1'b0; bus_rd = 1'b0; bus_wdata = '0;
    ext = 48'hA5C3_3C5A_0FF0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk("R1 pin_oe", pin_oe, 48'h0);
    chk("R1 pin_out", pin_out, 48'h0);
    chk("R1 rdata", {40'h0, bus_rdata}, 48'h0);
    do_read(3'd3, rv); chk("R1 ctl bank1", {40'h0, rv}, 48'h9B);
    do_read(3'd7, rv); chk("R1 ctl bank2", {40'h0, rv}, 48'h9B);

    // R7 inputs read through the synchronizer
    idle(3);
    do_read(3'd0, rv); chk("R7 bank1 A", {40'h0, rv}, {40'h0, ext[7:0]});
    // R11 bank 2 port C is lines 40..47
    do_read(3'd6, rv); chk("R11 bank2 C", {40'h0, rv}, {40'h0, ext[47:40]});
    // R10 idle cycle gives zero read data
    idle(1); chk("R10 idle rdata", {40'h0, bus_rdata}, 48'h0);

    // R9 latch written while input
    do_write(3'd0, 8'h5A);
    chk("R9 latch while input", {40'h0, pin_out[7:0]}, 48'h5A);
    chk("R9 oe still off", {40'h0, pin_oe[7:0]}, 48'h0);

    // R6 all outputs on bank 1, bank 2 untouched
    do_write(3'd3, 8'h80);
    chk("R6 bank1 oe", {24'h0, pin_oe[23:0]}, 48'hFF_FFFF);
    chk("R6 bank2 oe", {24'h0, pin_oe[47:24]}, 48'h0);
    chk("R9 latch kept", {40'h0, pin_out[7:0]}, 48'h5A);
    do_read(3'd3, rv); chk("R8 ctl readback", {40'h0, rv}, 48'h80);
    idle(3);
    do_read(3'd0, rv); chk("R7 loopback", {40'h0, rv}, 48'h5A);

    // R5 control byte without accept flag
    do_write(3'd3, 8'h10);
    chk("R5 oe kept", {24'h0, pin_oe[23:0]}, 48'hFF_FFFF);
    do_read(3'd3, rv); chk("R5 ctl kept", {40'h0, rv}, 48'h80);

    // R4 port C nibbles
    do_write(3'd7, 8'h88);
    chk("R4 C hi input", {44'h0, pin_oe[47:44]}, 48'h0);
    chk("R4 C lo output", {44'h0, pin_oe[43:40]}, 48'hF);
    do_write(3'd7, 8'h81);
    chk("R4 C hi output", {44'h0, pin_oe[47:44]}, 48'hF);
    chk("R4 C lo input", {44'h0, pin_oe[43:40]}, 48'h0);

    // R3 ports A and B
    do_write(3'd7, 8'h90);
    chk("R3 A input", {40'h0, pin_oe[31:24]}, 48'h0);
    chk("R3 B output", {40'h0, pin_oe[39:32]}, 48'hFF);
    do_write(3'd7, 8'h82);
    chk("R3 A output", {40'h0, pin_oe[31:24]}, 48'hFF);
    chk("R3 B input", {40'h0, pin_oe[39:32]}, 48'h0);

    // R2 port writes in bank 2
    do_write(3'd6, 8'h3C);
    chk("R2 bank2 C", {40'h0, pin_out[47:40]}, 48'h3C);
    do_write(3'd4, 8'hE7);
    chk("R2 bank2 A", {40'h0, pin_out[31:24]}, 48'hE7);
    // R11 bit 0 of bank 2 port B is pin 32
    do_write(3'd5, 8'h01);
    chk("R11 pin 32", {47'h0, pin_out[32]}, 48'h1);
    chk("R11 pin 33", {47'h0, pin_out[33]}, 48'h0);

    ext = 48'h1234_5678_9ABC;
    idle(4);
    do_read(3'd5, rv); chk("R7 bank2 B input", {40'h0, rv}, {40'h0, ext[39:32]});
    do_read(3'd4, rv); chk("R7 bank2 A loopback", {40'h0, rv}, 48'hE7);

    idle(2);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule